// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the MDIO management bus. Software places a register address or a write value in the block's 16-bit holding registers and then writes one command word that names the frame kind (Clause 22 or Clause 45), the opcode, the port and the device or register number, with a go bit set. The block sends one complete management frame on MDC/MDIO. The go bit reads back as 1 while the frame is on the wire and clears itself when the frame ends. A Clause 45 access takes two commands: an address frame that carries the address register, then a data frame.

MDC is divided down from the system clock by the `CLK_DIV` parameter, which defaults to 64. The master changes MDIO on the falling edge of MDC and samples it on the rising edge. On read frames the master lets go of MDIO from the turnaround onward. If the PHY fails to pull the second turnaround bit low, the master records a failed read.

The frame engine has five states. IDLE goes to PREAMBLE on launch. PREAMBLE goes to HEADER once 32 ones have been sent. HEADER goes to TURN after the 14 kind, opcode, port and device bits. TURN goes to DATA after the 2 turnaround bits. DATA goes back to IDLE after the 16 data bits, and that last step is the completion.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset every register reads 0, including the go bit (command bit 14) and status bit 0. MDC is low and `mdio_oe` is low.
- R2: The byte offsets are: command at 0x00, address at 0x04, write data at 0x08, read data at 0x0C and status at 0x10. The address and write-data registers store bits 15:0 of a write, and their upper bits read 0. Writes to read data or status have no effect. Command bits 4:0 hold the device or register number, 9:5 the port, 11:10 the opcode and 13:12 the frame kind, and all of these read back.
- R3: A command write with bit 14 set, made while the master is idle, starts a frame. Bit 14 reads 1 from the next cycle until the frame completes, then reads 0.
- R4: The wire order, MSB first, is: 32 ones, the 2-bit kind field (0 = Clause 45, 1 = Clause 22), the 2-bit opcode, 5 port bits, 5 device bits, the turnaround 10 on writes, and 16 data bits. The data is the address register for kind 0 opcode 0, and the write-data register for every other write.
- R5: While busy, MDC has a period of `CLK_DIV` system clocks. MDIO changes only while MDC is low. MDC stays low while idle.
- R6: A frame is a read when opcode bit 1 is set. On a read, `mdio_oe` is high for the first 46 bits and low for the remaining 18. The 16 data bits sampled after the turnaround are loaded into the read-data register, MSB first.
- R7: At the end of each read, status bit 0 is set to the value the PHY drove on the second turnaround bit, so 1 marks a failed read. Write and address frames leave the status unchanged.
- R8: A Clause 45 read-increment (kind 0, opcode 2) adds 1 to the address register when it completes, wrapping from 0xFFFF to 0. A Clause 22 read (kind 1, opcode 2) leaves the address register unchanged.
- R9: While a frame is in progress, writes to the command, address and write-data registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value sampled from the wire |

## Verification
The assertions check four behaviours on every cycle. The go bit stays set until completion and drops right after it. MDC stays low while idle, and MDIO holds steady while MDC is high. A read-increment advances the address by exactly one, and an address write during a frame is discarded. Only the bench scenarios can show that the bit sequence on the wire matches the command for every kind and opcode pair. The same holds for the output-enable pattern on reads, the MDC period, the captured read data, and the pass/fail turnaround outcome in the status bit.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int REG_AW     = 5;
    localparam int REG_DW     = 32;
    localparam int FIELD_W    = 16;

    localparam logic [REG_AW-1:0] OFF_CMD   = 5'h00;
    localparam logic [REG_AW-1:0] OFF_ADDR  = 5'h04;
    localparam logic [REG_AW-1:0] OFF_WDATA = 5'h08;
    localparam logic [REG_AW-1:0] OFF_RDATA = 5'h0C;
    localparam logic [REG_AW-1:0] OFF_STAT  = 5'h10;

    localparam int GO_BIT     = 14;

    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 14;
    localparam int TA_BITS    = 2;
    localparam int DAT_BITS   = 16;
    localparam int FRAME_BITS = PRE_BITS + HDR_BITS + TA_BITS + DAT_BITS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } frame_state_e;

    typedef struct packed {
        logic [1:0]         kind;
        logic [1:0]         op;
        logic [4:0]         port;
        logic [4:0]         dev;
        logic [FIELD_W-1:0] payload;
    } frame_req_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int CLK_DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = $clog2(HALF + 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc      = mdc_q;
    assign rise_stb = en & wrap & ~mdc_q;
    assign fall_stb = en & wrap & mdc_q;

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  frame_req_t         req,
    input  logic               rise_stb,
    input  logic               fall_stb,
    input  logic               mdio_i,
    output logic               busy,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               done,
    output logic               done_read,
    output logic               done_incr,
    output logic               done_ta_ok,
    output logic [FIELD_W-1:0] done_data
);
    localparam int CNT_W   = $clog2(FRAME_BITS + 1);
    localparam int PRE_END = PRE_BITS;
    localparam int HDR_END = PRE_BITS + HDR_BITS;
    localparam int TA_END  = HDR_END + TA_BITS;
    localparam int TA_LAST = TA_END - 1;

    frame_state_e            state_q, state_d;
    logic [FRAME_BITS-1:0]   sr_q;
    logic [CNT_W-1:0]        bit_q;
    logic                    rd_q;
    logic                    incr_q;
    logic                    ta_ok_q;
    logic [FIELD_W-1:0]      cap_q;
    logic [1:0]              ta_code;

    assign ta_code = req.op[1] ? 2'b11 : 2'b10;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (launch) state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_stb && bit_q == CNT_W'(PRE_END))    state_d = ST_HEADER;
            ST_HEADER:   if (fall_stb && bit_q == CNT_W'(HDR_END))    state_d = ST_TURN;
            ST_TURN:     if (fall_stb && bit_q == CNT_W'(TA_END))     state_d = ST_DATA;
            ST_DATA:     if (fall_stb && bit_q == CNT_W'(FRAME_BITS)) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // shift, count and capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q    <= '1;
            bit_q   <= '0;
            rd_q    <= 1'b0;
            incr_q  <= 1'b0;
            ta_ok_q <= 1'b0;
            cap_q   <= '0;
        end else if (state_q == ST_IDLE) begin
            if (launch) begin
                sr_q    <= {{PRE_BITS{1'b1}}, req.kind, req.op, req.port,
                            req.dev, ta_code, req.payload};
                bit_q   <= '0;
                rd_q    <= req.op[1];
                incr_q  <= (req.kind == 2'd0) && (req.op == 2'd2);
                ta_ok_q <= 1'b0;
                cap_q   <= '0;
            end
        end else begin
            if (rise_stb) begin
                bit_q <= bit_q + 1'b1;
                if (bit_q == CNT_W'(TA_LAST)) ta_ok_q <= ~mdio_i;
                if (bit_q >= CNT_W'(TA_END))  cap_q <= {cap_q[FIELD_W-2:0], mdio_i};
            end
            if (fall_stb) sr_q <= {sr_q[FRAME_BITS-2:0], 1'b1};
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        mdio_o     = sr_q[FRAME_BITS-1];
        done       = (state_q == ST_DATA) && fall_stb && (bit_q == CNT_W'(FRAME_BITS));
        done_read  = rd_q;
        done_incr  = incr_q;
        done_ta_ok = ta_ok_q;
        done_data  = cap_q;
        unique case (state_q)
            ST_IDLE:                 mdio_oe = 1'b0;
            ST_PREAMBLE, ST_HEADER:  mdio_oe = 1'b1;
            ST_TURN, ST_DATA:        mdio_oe = ~rd_q;
            default:                 mdio_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int CLK_DIV = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [REG_DW-1:0] bus_wdata,
    output logic [REG_DW-1:0] bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic [1:0]         kind_q, op_q;
    logic [4:0]         port_q, dev_q;
    logic [FIELD_W-1:0] addr_q, wdata_q, rdata_q;
    logic               fail_q;

    logic               busy_w, done_w, done_read, done_incr, done_ta_ok;
    logic [FIELD_W-1:0] done_data;
    logic               rise_stb, fall_stb;
    logic               wr_ok, cmd_hit, launch;
    frame_req_t         req;

    assign wr_ok   = bus_wen && !busy_w;
    assign cmd_hit = wr_ok && (bus_addr == OFF_CMD);
    assign launch  = cmd_hit && bus_wdata[GO_BIT];

    always_comb begin
        req.kind    = bus_wdata[13:12];
        req.op      = bus_wdata[11:10];
        req.port    = bus_wdata[9:5];
        req.dev     = bus_wdata[4:0];
        req.payload = (bus_wdata[13:10] == 4'b0000) ? addr_q : wdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= '0;
            op_q    <= '0;
            port_q  <= '0;
            dev_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            fail_q  <= 1'b0;
        end else begin
            if (cmd_hit) begin
                kind_q <= req.kind;
                op_q   <= req.op;
                port_q <= req.port;
                dev_q  <= req.dev;
            end
            if (wr_ok && bus_addr == OFF_ADDR)  addr_q  <= bus_wdata[FIELD_W-1:0];
            if (wr_ok && bus_addr == OFF_WDATA) wdata_q <= bus_wdata[FIELD_W-1:0];
            if (done_w) begin
                if (done_read) begin
                    rdata_q <= done_data;
                    fail_q  <= ~done_ta_ok;
                end
                if (done_incr) addr_q <= addr_q + 1'b1;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            OFF_CMD:   bus_rdata = {17'd0, busy_w, kind_q, op_q, port_q, dev_q};
            OFF_ADDR:  bus_rdata = {16'd0, addr_q};
            OFF_WDATA: bus_rdata = {16'd0, wdata_q};
            OFF_RDATA: bus_rdata = {16'd0, rdata_q};
            OFF_STAT:  bus_rdata = {31'd0, fail_q};
            default:   bus_rdata = '0;
        endcase
    end

    mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (busy_w),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .req        (req),
        .rise_stb   (rise_stb),
        .fall_stb   (fall_stb),
        .mdio_i     (mdio_i),
        .busy       (busy_w),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .done       (done_w),
        .done_read  (done_read),
        .done_incr  (done_incr),
        .done_ta_ok (done_ta_ok),
        .done_data  (done_data)
    );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        incr,
    input logic        mdc,
    input logic        mdio_o,
    input logic        bus_wen,
    input logic [4:0]  bus_addr,
    input logic [15:0] addr_q
);
    p_go_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);

    p_go_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_mdc_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    p_mdio_steady_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mdc && $past(mdc) |-> $stable(mdio_o));

    p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && incr |=> addr_q == $past(addr_q) + 16'd1);

    p_addr_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && bus_wen && bus_addr == 5'h04 |=> $stable(addr_q));

endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy_w),
    .done     (done_w),
    .incr     (done_incr),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .bus_wen  (bus_wen),
    .bus_addr (bus_addr),
    .addr_q   (addr_q)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
    localparam int DIV = 4;
    localparam int MDC_NS = DIV * 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_addr = '0;
    logic [15:0] exp_wdata = '0;
    logic        exp_stat = 1'b0;

    always #10 clk = ~clk;

    mdio_mgmt_master #(.CLK_DIV(DIV)) u_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic run_frame(input logic [1:0] kind, input logic [1:0] op,
                             input logic [4:0] pa, input logic [4:0] da,
                             input logic ta2, input logic [15:0] rv, input bit poke);
        logic [15:0] pay;
        logic [63:0] exp_f, cap, oecap, exp_oe, mask;
        logic [31:0] v;
        logic        is_rd, per_bad;
        realtime     last_t;
        is_rd   = op[1];
        pay     = (kind == 2'd0 && op == 2'd0) ? exp_addr : exp_wdata;
        exp_f   = {32'hFFFF_FFFF, kind, op, pa, da, 2'b10, pay};
        mask    = is_rd ? {{46{1'b1}}, 18'd0} : '1;
        exp_oe  = is_rd ? {{46{1'b1}}, 18'd0} : '1;
        cap = '0; oecap = '0; per_bad = 1'b0; last_t = 0;
        wr(5'h00, {17'd0, 1'b1, kind, op, pa, da});
        rd(5'h00, v);
        chk("R3 go bit set while busy", {49'd0, v[14:0]}, {49'd0, 1'b1, kind, op, pa, da});
        for (int k = 1; k <= 64; k++) begin
            @(posedge mdc); #1;
            cap   = {cap[62:0], mdio_o};
            oecap = {oecap[62:0], mdio_oe};
            if (k > 1 && ($realtime - last_t) != MDC_NS) per_bad = 1'b1;
            last_t = $realtime;
            if (poke && k == 10) wr(5'h04, 32'h0000_7E7E);
            if (poke && k == 12) wr(5'h00, {17'd0, 1'b1, 14'h3FFF});
            @(negedge mdc); #1;
            if (k == 46)                mdio_i = 1'b1;
            else if (k == 47)           mdio_i = ta2;
            else if (k >= 48 && k < 64) mdio_i = rv[63-k];
            else                        mdio_i = 1'b1;
        end
        repeat (3) @(negedge clk);
        rd(5'h00, v);
        chk("R3 go bit cleared after frame", {63'd0, v[14]}, 64'd0);
        chk("R4 wire bits", cap & mask, exp_f & mask);
        chk("R6 output enable pattern", oecap, exp_oe);
        chk("R5 mdc period", {63'd0, per_bad}, 64'd0);
        if (is_rd) begin
            exp_stat = ta2;
            if (!ta2) begin
                rd(5'h0C, v);
                chk("R6 read data", {32'd0, v}, {48'd0, rv});
            end
        end
        rd(5'h10, v);
        chk("R7 status", {32'd0, v}, {63'd0, exp_stat});
        if (kind == 2'd0 && op == 2'd2) exp_addr = exp_addr + 16'd1;
        rd(5'h04, v);
        chk("R8 address after frame", {32'd0, v}, {48'd0, exp_addr});
        if (poke) begin
            rd(5'h00, v);
            chk("R9 command unchanged by busy write", {50'd0, v[13:0]}, {50'd0, kind, op, pa, da});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        for (int a = 0; a <= 16; a += 4) begin
            rd(5'(a), v);
            chk("R1 register reset value", {32'd0, v}, 64'd0);
        end
        chk("R1 mdc and oe idle", {62'd0, mdc, mdio_oe}, 64'd0);
        // R2
        wr(5'h04, 32'hDEAD_1234); exp_addr = 16'h1234;
        wr(5'h08, 32'hBEEF_A5C3); exp_wdata = 16'hA5C3;
        wr(5'h0C, 32'hFFFF_FFFF);
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h04, v); chk("R2 address register", {32'd0, v}, 64'h1234);
        rd(5'h08, v); chk("R2 write-data register", {32'd0, v}, 64'hA5C3);
        rd(5'h0C, v); chk("R2 read-data is read-only", {32'd0, v}, 64'd0);
        rd(5'h10, v); chk("R2 status is read-only", {32'd0, v}, 64'd0);
        wr(5'h00, 32'h0000_2B6D);
        rd(5'h00, v); chk("R2 command fields no go", {32'd0, v}, 64'h2B6D);
        repeat (4) @(negedge clk);
        chk("R2 no frame without go", {63'd0, mdio_oe | mdc}, 64'd0);
        // sweep every kind/opcode pair with two port/device patterns
        for (int kd = 0; kd < 2; kd++)
            for (int o = 0; o < 4; o++)
                for (int p = 0; p < 2; p++)
                    run_frame(2'(kd), 2'(o), p ? 5'h15 : 5'h0A, p ? 5'h03 : 5'h1C,
                              1'b0, 16'hC3A5 ^ 16'(o * 16'h1111 + p * 16'h0F0F), 1'b0);
        // R7 failed turnaround, then a write keeps status, then a good read clears it
        run_frame(2'd1, 2'd2, 5'h01, 5'h02, 1'b1, 16'h5555, 1'b0);
        run_frame(2'd1, 2'd1, 5'h01, 5'h02, 1'b0, 16'h0000, 1'b0);
        run_frame(2'd0, 2'd3, 5'h01, 5'h02, 1'b0, 16'h8001, 1'b0);
        // R8 wrap of the read-increment
        wr(5'h04, 32'h0000_FFFF); exp_addr = 16'hFFFF;
        run_frame(2'd0, 2'd2, 5'h1F, 5'h1F, 1'b0, 16'h7FFE, 1'b0);
        // R9 writes during a frame are dropped
        run_frame(2'd1, 2'd1, 5'h11, 5'h05, 1'b0, 16'h0000, 1'b1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule